// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox with Fast A20

This block is the host-facing half of an 8042-style keyboard controller. It decodes a simple 8-bit I/O bus with active-low read and write strobes at three addresses. The data port (default 0x60) and the command/status port (default 0x64) share one input buffer. A command/data flag in the status register records which of the two ports wrote the buffer last. The output buffer is loaded by the internal controller and drained by host reads of the data port. The input-buffer-full and output-buffer-full flags make up the handshake between the two sides. The internal controller can also write the user-definable bits and the system flag of the status register.

Two hardware paths move the A20 gate without help from the internal processor. First, when speedup is enabled, the bus sequence "command 0xD1, then one data byte" is taken over by hardware. Bit 1 of that data byte becomes the keyboard-side A20 level, and neither byte reaches the input buffer. Second, a fast-control register (default address 0x92) drives its own A20 level from bit 1. A rising write of bit 0 in that register fires a fixed-length CPU reset pulse. The block ORs the two A20 sources together. It ANDs the reset pulse into the active-low keyboard reset that comes from the internal controller.

Each host access is a single clock cycle with the strobe held low. Read data is combinational from the address while the read strobe is low.

Top module: `kbc_mailbox_top`

## Requirements
- R1: A host write to the data port stores the byte in the input buffer, sets IBF (status bit 1) and clears C/D (status bit 3), unless hardware takes the write over (R8).
- R2: A host write to the command port stores the byte in the input buffer and sets both IBF and C/D, unless hardware takes the write over (R7). The status register itself is not written by the host.
- R3: After reset, the status register reads 0x00, the fast-control register reads 0x20, gate_a20 is 0 and cpu_rst_n follows kb_rst_n.
- R4: A controller status write changes only bits 7:4 (user-defined) and bit 2 (system flag). OBF (bit 0), IBF and C/D keep their values.
- R5: A controller output-buffer write sets OBF (bit 0). A host read of the data port returns that byte and clears OBF.
- R6: A controller input-buffer read returns the last stored byte and clears IBF.
- R7: With speedup enabled, a command-port write of 0xD1 arms the sequence and changes neither the input buffer nor the status register.
- R8: While the sequence is armed, the next data-port write sets the keyboard-side A20 to data bit 1 and disarms. The write leaves IBF and C/D unchanged.
- R9: A command-port write of any value other than 0xD1 disarms the sequence and is then stored as a normal command (R2).
- R10: Reading the fast-control register returns bits 7:6 = 00, bit 5 = 1, bits 4:2 = 000, bit 1 = fast A20 and bit 0 = the stored reset bit.
- R11: A write that changes fast-control bit 0 from 0 to 1 drives cpu_rst_n low for exactly RST_PULSE cycles (default 8). A write of 1 while the bit is already 1 starts no pulse.
- R12: gate_a20 is the OR of the keyboard-side A20 and fast-control bit 1. cpu_rst_n is kb_rst_n ANDed with the inverse of the reset pulse.
- R13: With speedup disabled, 0xD1 and the following data byte are stored in the input buffer as normal, and A20 does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_rd_n | input | 1 | Host read strobe, active low, one cycle per access |
| io_wr_n | input | 1 | Host write strobe, active low, one cycle per access |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid while io_rd_n is low |
| speedup_en | input | 1 | Enables hardware takeover of the 0xD1 sequence |
| uc_ib_rd | input | 1 | Controller reads the input buffer (clears IBF) |
| uc_ib_data | output | 8 | Input buffer contents |
| uc_ob_wr | input | 1 | Controller loads the output buffer |
| uc_ob_data | input | 8 | Output buffer load value |
| uc_st_wr | input | 1 | Controller writes the status user bits and system flag |
| uc_st_data | input | 8 | Status write value |
| uc_status | output | 8 | Current status register |
| uc_a20_wr | input | 1 | Controller sets the keyboard-side A20 |
| uc_a20_val | input | 1 | Value for uc_a20_wr |
| kb_rst_n | input | 1 | Active-low reset request from the controller |
| gate_a20 | output | 1 | Combined A20 gate |
| cpu_rst_n | output | 1 | Combined active-low CPU reset |

## Verification
The bench first confirms that the 0xD1 sequence is taken over in hardware with data bit 1 both set and clear. A design that let the bytes through would raise IBF, and one that decoded the wrong bit would leave A20 stuck. It then sends an ordinary command between 0xD1 and the data byte. A design that did not disarm would take the later data byte for A20 instead of buffering it. Further checks cover the reset pulse: its length is counted cycle by cycle, and a second write of 1 must start no new pulse. With speedup disabled, 0xD1 must pass through to the input buffer. The remaining checks exercise the IBF and OBF handshakes and the status mask. A design that let controller status writes reach OBF, IBF or C/D would show wrong flags on the next status read.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
   localparam int ST_OBF = 0;
   localparam int ST_IBF = 1;
   localparam int ST_SYS = 2;
   localparam int ST_CD  = 3;
   // bits the internal controller may overwrite: user nibble and system flag
   localparam logic [7:0] UC_ST_MASK = 8'hF4;
   localparam logic [7:0] CMD_WR_OUTPORT = 8'hD1;
   // fast-control readback template: bits 7:6 zero, bit 5 one
   localparam logic [7:0] FAST_RD_FIXED = 8'h20;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_CMD  = 2'd1,
      SEL_FAST = 2'd2
   } port_sel_e;
endpackage

// File: rtl/kbc_host_decode.sv
module kbc_host_decode #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] DATA_ADDR = 16'h0060,
   parameter logic [15:0] CMD_ADDR  = 16'h0064,
   parameter logic [15:0] FAST_ADDR = 16'h0092
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_n,
   input  logic              wr_n,
   output logic [2:0]        rd_hit,
   output logic [2:0]        wr_hit
);
   import kbc_pkg::*;
   localparam int NPORT = 3;
   localparam logic [NPORT*16-1:0] PORT_LIST = {FAST_ADDR, CMD_ADDR, DATA_ADDR};

   initial begin
      if (ADDR_W < 8 || ADDR_W > 16) $error("ADDR_W out of range");
      if (DATA_ADDR == CMD_ADDR || DATA_ADDR == FAST_ADDR || CMD_ADDR == FAST_ADDR)
         $error("port addresses must differ");
   end

   logic [NPORT-1:0] hit;
   for (genvar g = 0; g < NPORT; g++) begin : g_port
      assign hit[g] = (addr == PORT_LIST[g*16 +: ADDR_W]);
   end

   assign rd_hit = hit & {NPORT{~rd_n}};
   assign wr_hit = hit & {NPORT{~wr_n}};
endmodule

// File: rtl/kbc_a20_snoop.sv
module kbc_a20_snoop (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       wr_data,
   input  logic       wr_cmd,
   input  logic [7:0] wdata,
   input  logic       uc_a20_wr,
   input  logic       uc_a20_val,
   output logic       take_data,
   output logic       take_cmd,
   output logic       kbc_a20
);
   import kbc_pkg::*;
   logic armed_q, a20_q;

   assign take_cmd  = enable && wr_cmd && (wdata == CMD_WR_OUTPORT);
   assign take_data = armed_q && wr_data;
   assign kbc_a20   = a20_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         a20_q   <= 1'b0;
      end else begin
         if (take_cmd)       armed_q <= 1'b1;
         else if (wr_cmd)    armed_q <= 1'b0;
         else if (take_data) armed_q <= 1'b0;
         if (take_data)      a20_q <= wdata[1];
         else if (uc_a20_wr) a20_q <= uc_a20_val;
      end
   end

   assert_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && wr_cmd && wdata == CMD_WR_OUTPORT) |=> armed_q);
   assert_a20_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && wr_data) |=> (kbc_a20 == $past(wdata[1])) && !armed_q);
   assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && wr_cmd && wdata != CMD_WR_OUTPORT) |=> !armed_q);
endmodule

// File: rtl/kbc_buffers.sv
module kbc_buffers #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_data,
   input  logic          wr_cmd,
   input  logic          rd_data,
   input  logic [DW-1:0] wdata,
   input  logic          uc_ib_rd,
   input  logic          uc_ob_wr,
   input  logic [DW-1:0] uc_ob_data,
   input  logic          uc_st_wr,
   input  logic [DW-1:0] uc_st_data,
   output logic [DW-1:0] ib,
   output logic [DW-1:0] ob,
   output logic [DW-1:0] status
);
   import kbc_pkg::*;
   initial if (DW != 8) $error("status layout needs DW of 8");

   logic [DW-1:0] ib_q, ob_q, st_q, st_n;

   always_comb begin
      st_n = st_q;
      if (uc_st_wr) st_n = (st_q & ~UC_ST_MASK) | (uc_st_data & UC_ST_MASK);
      if (uc_ob_wr)     st_n[ST_OBF] = 1'b1;
      else if (rd_data) st_n[ST_OBF] = 1'b0;
      if (wr_data || wr_cmd) st_n[ST_IBF] = 1'b1;
      else if (uc_ib_rd)     st_n[ST_IBF] = 1'b0;
      if (wr_data)     st_n[ST_CD] = 1'b0;
      else if (wr_cmd) st_n[ST_CD] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ib_q <= '0;
         ob_q <= '0;
         st_q <= '0;
      end else begin
         st_q <= st_n;
         if (wr_data || wr_cmd) ib_q <= wdata;
         if (uc_ob_wr)          ob_q <= uc_ob_data;
      end
   end

   assign ib     = ib_q;
   assign ob     = ob_q;
   assign status = st_q;

   assert_data_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> st_q[ST_IBF] && !st_q[ST_CD] && ib_q == $past(wdata));
   assert_cmd_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd |=> st_q[ST_IBF] && st_q[ST_CD]);
   assert_reset_clear_R3: assert property (@(posedge clk)
      !rst_n |=> st_q == '0);
   assert_obf_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !uc_ob_wr) |=> !st_q[ST_OBF]);
   assert_ibf_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (uc_ib_rd && !wr_data && !wr_cmd) |=> !st_q[ST_IBF]);
   assert_flag_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (uc_st_wr && !uc_ob_wr && !rd_data && !wr_data && !wr_cmd && !uc_ib_rd)
      |=> (st_q & ~UC_ST_MASK) == ($past(st_q) & ~UC_ST_MASK));
endmodule

// File: rtl/kbc_fast_ctl.sv
module kbc_fast_ctl #(
   parameter int RST_PULSE = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] wbits,
   output logic [7:0] rd_value,
   output logic       fast_a20,
   output logic       rst_pulse
);
   import kbc_pkg::*;
   localparam int CW = $clog2(RST_PULSE + 1);
   localparam logic [CW-1:0] LOAD = CW'(RST_PULSE);
   initial if (RST_PULSE < 1) $error("RST_PULSE must be at least 1");

   logic [1:0]    bits_q;
   logic [CW-1:0] cnt_q;
   logic          fire;

   assign fire = wr && wbits[0] && !bits_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr) bits_q <= wbits;
         if (fire)             cnt_q <= LOAD;
         else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign rd_value  = FAST_RD_FIXED | {6'd0, bits_q};
   assign fast_a20  = bits_q[1];
   assign rst_pulse = (cnt_q != '0);

   assert_pulse_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wbits[0] && !bits_q[0]) |=> rst_pulse);
   assert_no_retrigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/kbc_mailbox_top.sv
module kbc_mailbox_top #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] DATA_ADDR = 16'h0060,
   parameter logic [15:0] CMD_ADDR  = 16'h0064,
   parameter logic [15:0] FAST_ADDR = 16'h0092,
   parameter int          RST_PULSE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd_n,
   input  logic              io_wr_n,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic              speedup_en,
   input  logic              uc_ib_rd,
   output logic [7:0]        uc_ib_data,
   input  logic              uc_ob_wr,
   input  logic [7:0]        uc_ob_data,
   input  logic              uc_st_wr,
   input  logic [7:0]        uc_st_data,
   output logic [7:0]        uc_status,
   input  logic              uc_a20_wr,
   input  logic              uc_a20_val,
   input  logic              kb_rst_n,
   output logic              gate_a20,
   output logic              cpu_rst_n
);
   import kbc_pkg::*;

   logic [2:0] rd_hit, wr_hit;
   logic       take_data, take_cmd, kbc_a20, fast_a20, rst_pulse;
   logic [7:0] ob, fast_rd;

   kbc_host_decode #(
      .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR),
      .CMD_ADDR(CMD_ADDR), .FAST_ADDR(FAST_ADDR)
   ) u_dec (
      .addr(io_addr), .rd_n(io_rd_n), .wr_n(io_wr_n),
      .rd_hit(rd_hit), .wr_hit(wr_hit)
   );

   kbc_a20_snoop u_snoop (
      .clk(clk), .rst_n(rst_n), .enable(speedup_en),
      .wr_data(wr_hit[SEL_DATA]), .wr_cmd(wr_hit[SEL_CMD]), .wdata(io_wdata),
      .uc_a20_wr(uc_a20_wr), .uc_a20_val(uc_a20_val),
      .take_data(take_data), .take_cmd(take_cmd), .kbc_a20(kbc_a20)
   );

   kbc_buffers #(.DW(8)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_data(wr_hit[SEL_DATA] && !take_data),
      .wr_cmd(wr_hit[SEL_CMD] && !take_cmd),
      .rd_data(rd_hit[SEL_DATA]), .wdata(io_wdata),
      .uc_ib_rd(uc_ib_rd), .uc_ob_wr(uc_ob_wr), .uc_ob_data(uc_ob_data),
      .uc_st_wr(uc_st_wr), .uc_st_data(uc_st_data),
      .ib(uc_ib_data), .ob(ob), .status(uc_status)
   );

   kbc_fast_ctl #(.RST_PULSE(RST_PULSE)) u_fast (
      .clk(clk), .rst_n(rst_n), .wr(wr_hit[SEL_FAST]), .wbits(io_wdata[1:0]),
      .rd_value(fast_rd), .fast_a20(fast_a20), .rst_pulse(rst_pulse)
   );

   always_comb begin
      io_rdata = '0;
      if (rd_hit[SEL_DATA])      io_rdata = ob;
      else if (rd_hit[SEL_CMD])  io_rdata = uc_status;
      else if (rd_hit[SEL_FAST]) io_rdata = fast_rd;
   end

   assign gate_a20  = kbc_a20 | fast_a20;
   assign cpu_rst_n = kb_rst_n & ~rst_pulse;

   assert_take_no_ibf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_data && !uc_ib_rd && !wr_hit[SEL_CMD]) |=> $stable(uc_status[ST_IBF]));
   assert_a20_or_R12: assert property (@(posedge clk) disable iff (!rst_n)
      fast_a20 |-> gate_a20);
endmodule

// File: tb/tb_kbc_mailbox_top.sv
module tb_kbc_mailbox_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd_n = 1'b1, io_wr_n = 1'b1;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        speedup_en = 1'b1;
   logic        uc_ib_rd = 1'b0, uc_ob_wr = 1'b0, uc_st_wr = 1'b0;
   logic [7:0]  uc_ob_data = '0, uc_st_data = '0;
   logic [7:0]  uc_ib_data, uc_status;
   logic        uc_a20_wr = 1'b0, uc_a20_val = 1'b0;
   logic        kb_rst_n = 1'b1;
   logic        gate_a20, cpu_rst_n;

   int total = 0, bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   kbc_mailbox_top dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd_n(io_rd_n),
      .io_wr_n(io_wr_n), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .speedup_en(speedup_en), .uc_ib_rd(uc_ib_rd), .uc_ib_data(uc_ib_data),
      .uc_ob_wr(uc_ob_wr), .uc_ob_data(uc_ob_data), .uc_st_wr(uc_st_wr),
      .uc_st_data(uc_st_data), .uc_status(uc_status), .uc_a20_wr(uc_a20_wr),
      .uc_a20_val(uc_a20_val), .kb_rst_n(kb_rst_n), .gate_a20(gate_a20),
      .cpu_rst_n(cpu_rst_n)
   );

   // vector kinds
   localparam logic [2:0] K_HW = 3'd0;  // host write addr,data
   localparam logic [2:0] K_HR = 3'd1;  // host read addr, expect data
   localparam logic [2:0] K_IB = 3'd2;  // controller reads input buffer, expect data
   localparam logic [2:0] K_OB = 3'd3;  // controller loads output buffer
   localparam logic [2:0] K_ST = 3'd4;  // controller writes status
   localparam logic [2:0] K_A  = 3'd5;  // expect gate_a20 == data[0]
   localparam int NV = 38;
   // each entry: kind, address, data/expect, requirement number
   localparam logic [34:0] VEC [0:NV-1] = '{
      {K_HW, 16'h0060, 8'h5A, 8'd1},
      {K_HR, 16'h0064, 8'h02, 8'd1},
      {K_IB, 16'h0000, 8'h5A, 8'd6},
      {K_HR, 16'h0064, 8'h00, 8'd6},
      {K_HW, 16'h0064, 8'hAA, 8'd2},
      {K_HR, 16'h0064, 8'h0A, 8'd2},
      {K_IB, 16'h0000, 8'hAA, 8'd2},
      {K_OB, 16'h0000, 8'h3C, 8'd5},
      {K_HR, 16'h0064, 8'h09, 8'd5},
      {K_HR, 16'h0060, 8'h3C, 8'd5},
      {K_HR, 16'h0064, 8'h08, 8'd5},
      {K_ST, 16'h0000, 8'hFF, 8'd4},
      {K_HR, 16'h0064, 8'hFC, 8'd4},
      {K_ST, 16'h0000, 8'h00, 8'd4},
      {K_HR, 16'h0064, 8'h08, 8'd4},
      {K_HW, 16'h0064, 8'hD1, 8'd7},
      {K_HR, 16'h0064, 8'h08, 8'd7},
      {K_HW, 16'h0060, 8'h02, 8'd8},
      {K_A,  16'h0000, 8'h01, 8'd8},
      {K_HR, 16'h0064, 8'h08, 8'd8},
      {K_HW, 16'h0064, 8'hD1, 8'd8},
      {K_HW, 16'h0060, 8'hFD, 8'd8},
      {K_A,  16'h0000, 8'h00, 8'd8},
      {K_HR, 16'h0064, 8'h08, 8'd8},
      {K_HW, 16'h0064, 8'hD1, 8'd9},
      {K_HW, 16'h0064, 8'hFF, 8'd9},
      {K_HR, 16'h0064, 8'h0A, 8'd9},
      {K_IB, 16'h0000, 8'hFF, 8'd9},
      {K_HW, 16'h0060, 8'h02, 8'd9},
      {K_A,  16'h0000, 8'h00, 8'd9},
      {K_HR, 16'h0064, 8'h02, 8'd9},
      {K_IB, 16'h0000, 8'h02, 8'd9},
      {K_HW, 16'h0092, 8'h02, 8'd12},
      {K_A,  16'h0000, 8'h01, 8'd12},
      {K_HR, 16'h0092, 8'h22, 8'd10},
      {K_HW, 16'h0092, 8'h00, 8'd10},
      {K_A,  16'h0000, 8'h00, 8'd12},
      {K_HR, 16'h0092, 8'h20, 8'd10}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr_n = 1'b0;
      @(negedge clk);
      io_wr_n = 1'b1;
   endtask

   task automatic host_rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd_n = 1'b0;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd_n = 1'b1;
   endtask

   task automatic uc_pulse_ib(output logic [7:0] d);
      @(negedge clk);
      d = uc_ib_data; uc_ib_rd = 1'b1;
      @(negedge clk);
      uc_ib_rd = 1'b0;
   endtask

   task automatic uc_load_ob(input logic [7:0] d);
      @(negedge clk);
      uc_ob_data = d; uc_ob_wr = 1'b1;
      @(negedge clk);
      uc_ob_wr = 1'b0;
   endtask

   task automatic uc_load_st(input logic [7:0] d);
      @(negedge clk);
      uc_st_data = d; uc_st_wr = 1'b1;
      @(negedge clk);
      uc_st_wr = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      // R3: reset state
      check("R3 status", uc_status, 8'h00);
      check("R3 a20", {7'd0, gate_a20}, 8'h00);
      check("R3 rst", {7'd0, cpu_rst_n}, 8'h01);
      rst_n = 1'b1;
      host_rd(16'h0092, r);
      check("R3 fast reg", r, 8'h20);

      for (int i = 0; i < NV; i++) begin
         logic [2:0]  k;
         logic [15:0] a;
         logic [7:0]  d;
         string       tag;
         k = VEC[i][34:32]; a = VEC[i][31:16]; d = VEC[i][15:8];
         tag = $sformatf("R%0d vec%0d", VEC[i][7:0], i);
         case (k)
            K_HW: host_wr(a, d);
            K_HR: begin host_rd(a, r); check(tag, r, d); end
            K_IB: begin uc_pulse_ib(r); check(tag, r, d); end
            K_OB: uc_load_ob(d);
            K_ST: uc_load_st(d);
            default: check(tag, {7'd0, gate_a20}, d);
         endcase
      end

      // R11: reset pulse length and no retrigger
      host_wr(16'h0092, 8'h01);
      for (int i = 0; i < 8; i++) begin
         check("R11 pulse low", {7'd0, cpu_rst_n}, 8'h00);
         @(negedge clk);
      end
      check("R11 pulse end", {7'd0, cpu_rst_n}, 8'h01);
      host_wr(16'h0092, 8'h01);
      check("R11 no retrigger", {7'd0, cpu_rst_n}, 8'h01);
      host_rd(16'h0092, r);
      check("R10 bit0 readback", r, 8'h21);
      host_wr(16'h0092, 8'h00);

      // R12: keyboard reset passes through
      kb_rst_n = 1'b0; #1;
      check("R12 kb reset", {7'd0, cpu_rst_n}, 8'h00);
      kb_rst_n = 1'b1;

      // R12: controller-side A20 path ORed
      @(negedge clk); uc_a20_wr = 1'b1; uc_a20_val = 1'b1;
      @(negedge clk); uc_a20_wr = 1'b0;
      check("R12 uc a20", {7'd0, gate_a20}, 8'h01);
      @(negedge clk); uc_a20_wr = 1'b1; uc_a20_val = 1'b0;
      @(negedge clk); uc_a20_wr = 1'b0;

      // R13: speedup disabled, 0xD1 passes through
      speedup_en = 1'b0;
      host_wr(16'h0064, 8'hD1);
      host_rd(16'h0064, r);
      check("R13 cmd buffered", r, 8'h0A);
      uc_pulse_ib(r);
      check("R13 ib value", r, 8'hD1);
      host_wr(16'h0060, 8'h02);
      check("R13 a20 unchanged", {7'd0, gate_a20}, 8'h00);
      uc_pulse_ib(r);
      check("R13 data buffered", r, 8'h02);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule